// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer with Direction Counters

This block predicts the address the fetch unit requests next. Each cycle it takes the fetch PC and produces a next PC. If the PC matches a stored branch and that branch's counter leans taken, the next PC is the stored target. In every other case the next PC is the sequential address, PC+4. The lookup path is purely combinational from the fetch PC to the next PC.

Branches are resolved later in the pipeline. A synchronous update port reports the branch PC, whether the branch was taken, and its destination address. The table is direct-mapped. Each entry holds a valid flag, the full branch PC used as a tag, a target address and a 2-bit saturating direction counter. Storing the whole PC means an unrelated instruction that shares an index can never pick up another branch's target.

Top module: `btb_next_pc`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until a taken branch is written.
- R2: On a miss, `pred_hit_o` and `pred_taken_o` are 0 and `next_pc_o` is `fetch_pc_i + 4`, wrapping modulo 2^PC_W.
- R3: A hit requires the stored branch PC to equal all bits of `fetch_pc_i`. A PC that shares the index but differs in any other bit misses.
- R4: On a hit, the upper counter bit decides the prediction. Counter values 2'b10 and 2'b11 give `pred_taken_o`=1 and `next_pc_o` = stored target. Values 2'b00 and 2'b01 give `pred_taken_o`=0 and `next_pc_o` = PC+4.
- R5: On an update that hits, the counter moves one step: up on taken and down on not taken. It saturates at 2'b11 and 2'b00, so a strongly biased entry changes its prediction only after two opposite outcomes in a row.
- R6: A taken update that misses writes the entry selected by PC bits [7:2]. The entry gets valid=1, the full PC, the reported target and counter 2'b10. This replaces whatever branch held that index.
- R7: A not-taken update that misses changes nothing, including a valid entry of a different branch at the same index.
- R8: An update that hits rewrites the stored target with `upd_target_i`, in addition to stepping the counter.
- R9: An update becomes visible to lookups from the cycle after it is presented. A lookup in the same cycle sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_pc_i | input | PC_W | Current fetch address |
| next_pc_o | output | PC_W | Predicted next fetch address |
| pred_hit_o | output | 1 | Fetch PC matched a valid entry |
| pred_taken_o | output | 1 | Redirect to the stored target |
| upd_valid_i | input | 1 | Resolved-branch report present |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual direction, 1 = taken |
| upd_target_i | input | PC_W | Branch destination address |

## Verification
A corrupted counter appears at `pred_taken_o` and `next_pc_o` on the first lookup of that PC after the faulty update. The bench therefore walks one entry through every counter state, including both saturation ends, and looks the entry up after each step. A wrong tag or valid bit shows up either as a false hit on an aliasing PC or as a missing hit on the original PC. Both are probed in the cycle right after the relevant update. Same-cycle lookups catch any write path that leaks new contents into the current cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  localparam ctr_e CTR_ALLOC = CTR_WT;

  function automatic ctr_e ctr_step(ctr_e c, logic tk);
    ctr_e n;
    unique case (c)
      CTR_SNT: n = tk ? CTR_WNT : CTR_SNT;
      CTR_WNT: n = tk ? CTR_WT  : CTR_SNT;
      CTR_WT:  n = tk ? CTR_ST  : CTR_WNT;
      default: n = tk ? CTR_ST  : CTR_WT;
    endcase
    return n;
  endfunction

  function automatic logic ctr_pred(ctr_e c);
    return c[1];
  endfunction

endpackage

// File: rtl/btb_table.sv
module btb_table
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output logic             rd_a_valid_o,
  output logic [PC_W-1:0]  rd_a_tag_o,
  output logic [PC_W-1:0]  rd_a_tgt_o,
  output ctr_e             rd_a_ctr_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic             rd_b_valid_o,
  output logic [PC_W-1:0]  rd_b_tag_o,
  output logic [PC_W-1:0]  rd_b_tgt_o,
  output ctr_e             rd_b_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PC_W-1:0]  wr_tag_i,
  input  logic [PC_W-1:0]  wr_tgt_i,
  input  ctr_e             wr_ctr_i
);
  localparam int N_ENT = 1 << IDX_W;

  logic            valid_q [N_ENT];
  logic [PC_W-1:0] tag_q   [N_ENT];
  logic [PC_W-1:0] tgt_q   [N_ENT];
  ctr_e            ctr_q   [N_ENT];

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  valid_q[i] <= 1'b0;
      else if (sel) valid_q[i] <= 1'b1;
    end

    // payload needs no reset: gated by valid
    always_ff @(posedge clk_i) begin
      if (sel) begin
        tag_q[i] <= wr_tag_i;
        tgt_q[i] <= wr_tgt_i;
        ctr_q[i] <= wr_ctr_i;
      end
    end
  end

  always_comb begin
    rd_a_valid_o = valid_q[rd_a_idx_i];
    rd_a_tag_o   = tag_q[rd_a_idx_i];
    rd_a_tgt_o   = tgt_q[rd_a_idx_i];
    rd_a_ctr_o   = ctr_q[rd_a_idx_i];
    rd_b_valid_o = valid_q[rd_b_idx_i];
    rd_b_tag_o   = tag_q[rd_b_idx_i];
    rd_b_tgt_o   = tgt_q[rd_b_idx_i];
    rd_b_ctr_o   = ctr_q[rd_b_idx_i];
  end

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int IDX_LSB = 2
) (
  input  logic [PC_W-1:0]  fetch_pc_i,
  output logic [IDX_W-1:0] idx_o,
  input  logic             ent_valid_i,
  input  logic [PC_W-1:0]  ent_tag_i,
  input  logic [PC_W-1:0]  ent_tgt_i,
  input  ctr_e             ent_ctr_i,
  output logic             hit_o,
  output logic             taken_o,
  output logic [PC_W-1:0]  next_pc_o
);
  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

  assign idx_o = fetch_pc_i[IDX_LSB +: IDX_W];

  always_comb begin
    // full-address compare: no partial-tag aliasing
    hit_o     = ent_valid_i && (ent_tag_i == fetch_pc_i);
    taken_o   = hit_o && ctr_pred(ent_ctr_i);
    next_pc_o = taken_o ? ent_tgt_i : fetch_pc_i + INSN_BYTES;
  end

endmodule

// File: rtl/btb_update.sv
module btb_update
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int IDX_LSB = 2
) (
  input  logic             upd_valid_i,
  input  logic [PC_W-1:0]  upd_pc_i,
  input  logic             upd_taken_i,
  input  logic [PC_W-1:0]  upd_target_i,
  output logic [IDX_W-1:0] idx_o,
  input  logic             ent_valid_i,
  input  logic [PC_W-1:0]  ent_tag_i,
  input  ctr_e             ent_ctr_i,
  output logic             wr_en_o,
  output logic [PC_W-1:0]  wr_tag_o,
  output logic [PC_W-1:0]  wr_tgt_o,
  output ctr_e             wr_ctr_o
);
  logic hit;

  assign idx_o = upd_pc_i[IDX_LSB +: IDX_W];
  assign hit   = ent_valid_i && (ent_tag_i == upd_pc_i);

  always_comb begin
    wr_en_o  = 1'b0;
    wr_tag_o = upd_pc_i;
    wr_tgt_o = upd_target_i;
    wr_ctr_o = CTR_ALLOC;
    if (upd_valid_i) begin
      if (hit) begin
        wr_en_o  = 1'b1;
        wr_ctr_o = ctr_step(ent_ctr_i, upd_taken_i);
      end else if (upd_taken_i) begin
        // allocate only taken branches; replaces the current occupant
        wr_en_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/btb_next_pc.sv
module btb_next_pc
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int IDX_LSB = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic [PC_W-1:0] next_pc_o,
  output logic            pred_hit_o,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_target_i
);
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic             lk_valid, up_valid;
  logic [PC_W-1:0]  lk_tag, lk_tgt, up_tag, up_tgt;
  ctr_e             lk_ctr, up_ctr;
  logic             wr_en;
  logic [PC_W-1:0]  wr_tag, wr_tgt;
  ctr_e             wr_ctr;

  btb_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_a_idx_i   (lk_idx),
    .rd_a_valid_o (lk_valid),
    .rd_a_tag_o   (lk_tag),
    .rd_a_tgt_o   (lk_tgt),
    .rd_a_ctr_o   (lk_ctr),
    .rd_b_idx_i   (up_idx),
    .rd_b_valid_o (up_valid),
    .rd_b_tag_o   (up_tag),
    .rd_b_tgt_o   (up_tgt),
    .rd_b_ctr_o   (up_ctr),
    .wr_en_i      (wr_en),
    .wr_idx_i     (up_idx),
    .wr_tag_i     (wr_tag),
    .wr_tgt_i     (wr_tgt),
    .wr_ctr_i     (wr_ctr)
  );

  btb_lookup #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_lookup (
    .fetch_pc_i  (fetch_pc_i),
    .idx_o       (lk_idx),
    .ent_valid_i (lk_valid),
    .ent_tag_i   (lk_tag),
    .ent_tgt_i   (lk_tgt),
    .ent_ctr_i   (lk_ctr),
    .hit_o       (pred_hit_o),
    .taken_o     (pred_taken_o),
    .next_pc_o   (next_pc_o)
  );

  btb_update #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_update (
    .upd_valid_i  (upd_valid_i),
    .upd_pc_i     (upd_pc_i),
    .upd_taken_i  (upd_taken_i),
    .upd_target_i (upd_target_i),
    .idx_o        (up_idx),
    .ent_valid_i  (up_valid),
    .ent_tag_i    (up_tag),
    .ent_ctr_i    (up_ctr),
    .wr_en_o      (wr_en),
    .wr_tag_o     (wr_tag),
    .wr_tgt_o     (wr_tgt),
    .wr_ctr_o     (wr_ctr)
  );

  // old target is unused by the update path
  logic unused_up_tgt;
  assign unused_up_tgt = ^up_tgt;

endmodule

// File: rtl/btb_next_pc_chk.sv
module btb_next_pc_chk #(
  parameter int PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] fetch_pc_i,
  input logic [PC_W-1:0] next_pc_o,
  input logic            pred_hit_o,
  input logic            pred_taken_o,
  input logic            upd_valid_i,
  input logic [PC_W-1:0] upd_pc_i,
  input logic            upd_taken_i
);
  logic alloc_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alloc_seen_q <= 1'b0;
    else if (upd_valid_i && upd_taken_i) alloc_seen_q <= 1'b1;
  end

  // R1
  empty_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alloc_seen_q |-> !pred_hit_o);

  // R2
  miss_sequential_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_hit_o |-> (!pred_taken_o && next_pc_o == fetch_pc_i + PC_W'(4)));

  // R4
  not_taken_sequential_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_taken_o |-> next_pc_o == fetch_pc_i + PC_W'(4));

  // R6
  taken_update_hits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i) |=> ((fetch_pc_i == $past(upd_pc_i)) |-> pred_hit_o));

  // R2
  outputs_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({pred_hit_o, pred_taken_o, next_pc_o}));

endmodule

bind btb_next_pc btb_next_pc_chk #(.PC_W(PC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_pc_i   (fetch_pc_i),
  .next_pc_o    (next_pc_o),
  .pred_hit_o   (pred_hit_o),
  .pred_taken_o (pred_taken_o),
  .upd_valid_i  (upd_valid_i),
  .upd_pc_i     (upd_pc_i),
  .upd_taken_i  (upd_taken_i)
);

// File: tb/btb_next_pc_tb.sv
`timescale 1ns/1ps
module btb_next_pc_tb;
  localparam int PC_W = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [PC_W-1:0] fetch_pc_i = '0;
  logic [PC_W-1:0] next_pc_o;
  logic            pred_hit_o, pred_taken_o;
  logic            upd_valid_i = 1'b0;
  logic [PC_W-1:0] upd_pc_i = '0;
  logic            upd_taken_i = 1'b0;
  logic [PC_W-1:0] upd_target_i = '0;

  always #10 clk_i = ~clk_i;

  btb_next_pc u_dut (.*);

  // reference model built from the requirements
  logic            m_v   [64];
  logic [PC_W-1:0] m_tag [64];
  logic [PC_W-1:0] m_tgt [64];
  logic [1:0]      m_ctr [64];

  logic [PC_W-1:0] q_pc[$], q_nxt[$];
  logic            q_hit[$], q_tk[$];
  string           q_req[$];

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic step(input logic [PC_W-1:0] pc, input logic uv,
                      input logic [PC_W-1:0] upc, input logic ut,
                      input logic [PC_W-1:0] utgt, input string req);
    int li, ui;
    logic h, t, uh;
    @(posedge clk_i); #2;
    fetch_pc_i = pc; upd_valid_i = uv; upd_pc_i = upc;
    upd_taken_i = ut; upd_target_i = utgt;
    li = int'(pc[7:2]);
    h = m_v[li] && m_tag[li] == pc;
    t = h && m_ctr[li][1];
    q_pc.push_back(pc); q_hit.push_back(h); q_tk.push_back(t);
    q_nxt.push_back(t ? m_tgt[li] : pc + 32'd4); q_req.push_back(req);
    if (uv) begin
      ui = int'(upc[7:2]);
      uh = m_v[ui] && m_tag[ui] == upc;
      if (uh) begin
        m_tgt[ui] = utgt;
        if (ut && m_ctr[ui] != 2'b11) m_ctr[ui] = m_ctr[ui] + 2'd1;
        if (!ut && m_ctr[ui] != 2'b00) m_ctr[ui] = m_ctr[ui] - 2'd1;
      end else if (ut) begin
        m_v[ui] = 1'b1; m_tag[ui] = upc; m_tgt[ui] = utgt; m_ctr[ui] = 2'b10;
      end
    end
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input string req);
    step(pc, 1'b0, '0, 1'b0, '0, req);
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] upc,
                     input logic ut, input logic [PC_W-1:0] utgt, input string req);
    step(pc, 1'b1, upc, ut, utgt, req);
  endtask

  // monitor: compare at the falling edge
  initial forever begin
    @(negedge clk_i);
    if (q_pc.size() > 0) begin
      logic [PC_W-1:0] pc, nx;
      logic h, t;
      string r;
      pc = q_pc.pop_front(); nx = q_nxt.pop_front();
      h = q_hit.pop_front(); t = q_tk.pop_front(); r = q_req.pop_front();
      checks++;
      if (pred_hit_o !== h || pred_taken_o !== t || next_pc_o !== nx) begin
        fails++;
        $display("FAIL %s pc=%h act hit=%b tk=%b nxt=%h exp hit=%b tk=%b nxt=%h",
                 r, pc, pred_hit_o, pred_taken_o, next_pc_o, h, t, nx);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  localparam logic [31:0] PA = 32'h0000_1040;
  localparam logic [31:0] PB = 32'h0004_1040; // same index as PA
  localparam logic [31:0] PC = 32'h0000_2080;
  localparam logic [31:0] PE = 32'h0000_00FC; // index 63

  initial begin
    for (int i = 0; i < 64; i++) begin m_v[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = '0; end
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    look(PA, "R1"); look(PB, "R1"); look(PE, "R1");
    look(32'hFFFF_FFFC, "R2");
    upd(PA, PA, 1'b0, 32'h3000, "R7");
    look(PA, "R7");
    upd(PA, PA, 1'b1, 32'h3000, "R9");   // same-cycle: old contents
    look(PA, "R6");
    look(PB, "R3");
    upd(PA, PA, 1'b0, 32'h3000, "R9");
    look(PA, "R4");
    upd(PA, PA, 1'b1, 32'h3000, "R5");
    upd(PA, PA, 1'b1, 32'h3000, "R5");
    upd(PA, PA, 1'b1, 32'h3000, "R5");   // saturate high
    upd(PA, PA, 1'b0, 32'h3000, "R5");
    upd(PA, PA, 1'b0, 32'h3000, "R5");
    upd(PA, PA, 1'b0, 32'h3000, "R5");
    upd(PA, PA, 1'b0, 32'h3000, "R5");   // saturate low
    upd(PA, PA, 1'b1, 32'h3000, "R5");
    upd(PA, PA, 1'b1, 32'h3000, "R5");
    look(PA, "R5");
    upd(PA, PA, 1'b1, 32'h5000, "R8");
    look(PA, "R8");
    upd(PA, PB, 1'b0, 32'h7000, "R7");
    look(PA, "R7"); look(PB, "R7");
    upd(PA, PB, 1'b1, 32'h7000, "R6");
    look(PB, "R6"); look(PA, "R3");
    upd(PE, PE, 1'b1, 32'h0000_0010, "R6");
    upd(PE, PC, 1'b1, 32'h0000_9000, "R6");
    look(PE, "R6"); look(PC, "R6"); look(PB, "R6");
    upd(PC, PC, 1'b0, 32'h0000_9000, "R4");
    look(PC, "R4");
    repeat (3) @(posedge clk_i);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule